// File: doc/BRIEF.md
# Key-Protected Cipher Control Register

This block is the software-facing control register of a four-channel block-cipher engine. A register bus writes a control word that picks the working channel, enables byte reversal on the CPU data paths and sends start and stop pulses to the engine. The same bus loads a bank of cipher keys: each channel holds several keys, and each key is a high word and a low word. The engine reads the keys of the selected channel from a flat key port.

The control word also holds a key-protect flag. Once software sets it, every read of a key register returns zero, although new keys can still be written. The flag is cleared only by a control write that has bit 31 low and the five-bit unlock code 10110 in bits [30:26]. That release also wipes every stored key. While the engine reports busy, the unlock field cannot be written, so protection cannot be released during an operation.

Reads are registered: `bus_rdata` holds the result from the cycle after `bus_rd` and keeps it until the next read.

Top module: `cipher_ctl_regs`

## Requirements
- R1: After reset the control word reads 0x0000_0000, every key register reads zero, and `eng_start`, `eng_stop`, `eng_chan`, `eng_din_vld` and `eng_key` are zero.
- R2: The control word at 0x200 reads back bit 31 (protect flag), bits [30:26] (unlock field), bits [25:24] (channel), bit 23 (input swap) and bit 22 (output swap). Every other bit reads 0, including the start bit 0 and the stop bit 1.
- R3: A control write with bit 0 set gives a one-cycle `eng_start` pulse in the cycle after the write. A control write with bit 1 set gives a one-cycle `eng_stop` pulse in the same way.
- R4: A control write with bit 31 = 1 sets the protect flag. A control write with bit 31 = 0 and any unlock field other than 10110 leaves the flag set.
- R5: While the flag is set, a read of any key register returns 0. Key writes are still stored, and they appear on `eng_key`.
- R6: A control write with bit 31 = 0, bits [30:26] = 10110 and `eng_busy` low clears the flag. If the flag was set, the same write also sets every key of every channel to zero. If the flag was clear, the keys are kept.
- R7: While `eng_busy` is high, a control write leaves the unlock field and the protect flag's release unchanged. The channel and swap fields still update.
- R8: `eng_chan` follows the channel field. `eng_key` carries the keys of that channel. Key k takes bits [k*64+63 : k*64]: its high word sits in the upper 32 bits and its low word in the lower 32 bits.
- R9: A write to 0x208 puts the write data on `eng_din` in the next cycle, with a one-cycle `eng_din_vld` pulse. When bit 23 is set, the bytes {b3,b2,b1,b0} arrive as {b0,b1,b2,b3}.
- R10: A read of 0x20C returns `eng_dout`. When bit 22 is set, the bytes come back reversed in the same way.
- R11: Key registers sit at 0x300 + channel*0x20 + key*8, with offset +0 for the high word and +4 for the low word, for keys 0 to 2. An address for key 3 reads 0, and a write to it stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| eng_busy | input | 1 | Engine is running an operation |
| eng_start | output | 1 | Start pulse toward the engine |
| eng_stop | output | 1 | Stop pulse toward the engine |
| eng_chan | output | 2 | Working channel |
| eng_din | output | 32 | CPU data toward the engine, after optional swap |
| eng_din_vld | output | 1 | Pulse marking new `eng_din` |
| eng_dout | input | 32 | Engine result data |
| eng_key | output | 192 | Keys of the working channel |

## Verification
The assertions assume a single-master bus: `bus_wr` and `bus_rd` are never high together, and accesses are word-aligned. The assertions that relate a release or a wipe to the write before it also assume that `eng_busy` is stable during the write cycle. The bench drives every strobe for exactly one cycle, with idle cycles between accesses. It changes `eng_busy` only between accesses and never asserts both strobes at once.

// File: rtl/cck_pkg.sv
package cck_pkg;
  localparam int CK_DATA_W   = 32;
  localparam int CK_ADDR_W   = 12;
  localparam int CK_NUM_CH   = 4;
  localparam int CK_KEYS     = 3;
  localparam int CK_CH_W     = 2;
  localparam int CK_KIDX_W   = 2;
  localparam int CK_HL_BIT   = 2;
  localparam int CK_KIDX_LSB = 3;
  localparam int CK_CH_LSB   = CK_KIDX_LSB + CK_KIDX_W;
  localparam int CK_KEY_TOP  = CK_CH_LSB + CK_CH_W;

  localparam logic [CK_ADDR_W-1:0] CK_CTL_ADDR  = 12'h200;
  localparam logic [CK_ADDR_W-1:0] CK_DIN_ADDR  = 12'h208;
  localparam logic [CK_ADDR_W-1:0] CK_DOUT_ADDR = 12'h20C;
  localparam logic [CK_ADDR_W-1:0] CK_KEY_BASE  = 12'h300;

  localparam logic [4:0] CK_UNLOCK_CODE = 5'b10110;

  typedef struct packed {
    logic       kprot;
    logic [4:0] unlock;
    logic [1:0] chan;
    logic       in_swap;
    logic       out_swap;
  } ctl_t;

  localparam int CK_CTL_FIELD_W = $bits(ctl_t);
endpackage

// File: rtl/cck_byte_swap.sv
module cck_byte_swap #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NBYTES = W / 8;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign dout[i*8 +: 8] = en ? din[(NBYTES-1-i)*8 +: 8] : din[i*8 +: 8];
  end
endmodule

// File: rtl/cck_ctl_reg.sv
module cck_ctl_reg
  import cck_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  ctl_t wr_fields,
  input  logic wr_start,
  input  logic wr_stop,
  input  logic busy,
  output ctl_t ctl_q,
  output logic start_q,
  output logic stop_q,
  output logic wipe
);
  ctl_t ctl_d;
  logic start_d;
  logic stop_d;
  logic code_ok;

  always_comb begin
    ctl_d   = ctl_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    wipe    = 1'b0;
    code_ok = (wr_fields.unlock == CK_UNLOCK_CODE);
    if (wr_ctl) begin
      ctl_d.chan     = wr_fields.chan;
      ctl_d.in_swap  = wr_fields.in_swap;
      ctl_d.out_swap = wr_fields.out_swap;
      start_d        = wr_start;
      stop_d         = wr_stop;
      if (!busy) begin
        ctl_d.unlock = wr_fields.unlock;
      end
      if (wr_fields.kprot) begin
        ctl_d.kprot = 1'b1;
      end else if (!busy && code_ok) begin
        ctl_d.kprot = 1'b0;
        wipe        = ctl_q.kprot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end
endmodule

// File: rtl/cck_key_bank.sv
module cck_key_bank
  import cck_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NCH    = 4,
  parameter int NKEYS  = 3,
  parameter int CHW    = 2,
  parameter int KIDXW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CHW-1:0]        wr_ch,
  input  logic [KIDXW-1:0]      wr_idx,
  input  logic                  wr_lo,
  input  logic [DW-1:0]         wdata,
  input  logic                  wipe,
  input  logic [CHW-1:0]        rd_ch,
  input  logic [KIDXW-1:0]      rd_idx,
  input  logic                  rd_lo,
  output logic [DW-1:0]         rd_word,
  input  logic [CHW-1:0]        sel_ch,
  output logic [NKEYS*2*DW-1:0] sel_keys
);
  logic [DW-1:0] hi_arr [NCH][NKEYS];
  logic [DW-1:0] lo_arr [NCH][NKEYS];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
      logic          hit;
      logic          hi_en;
      logic          lo_en;
      logic [DW-1:0] word_d;
      logic [DW-1:0] hi_q;
      logic [DW-1:0] lo_q;

      always_comb begin
        hit    = wr_en && (wr_ch == CHW'(c)) && (wr_idx == KIDXW'(k));
        hi_en  = wipe || (hit && !wr_lo);
        lo_en  = wipe || (hit && wr_lo);
        word_d = wipe ? '0 : wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q <= '0;
        end else if (hi_en) begin
          hi_q <= word_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
        end else if (lo_en) begin
          lo_q <= word_d;
        end
      end

      assign hi_arr[c][k] = hi_q;
      assign lo_arr[c][k] = lo_q;
    end
  end

  always_comb begin
    rd_word  = '0;
    sel_keys = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < NKEYS; k++) begin
        if (rd_ch == CHW'(c) && rd_idx == KIDXW'(k)) begin
          rd_word = rd_lo ? lo_arr[c][k] : hi_arr[c][k];
        end
        if (sel_ch == CHW'(c)) begin
          sel_keys[k*2*DW +: 2*DW] = {hi_arr[c][k], lo_arr[c][k]};
        end
      end
    end
  end
endmodule

// File: rtl/cipher_ctl_regs.sv
module cipher_ctl_regs
  import cck_pkg::*;
#(
  parameter int DATA_W      = CK_DATA_W,
  parameter int ADDR_W      = CK_ADDR_W,
  parameter int KEYS_PER_CH = CK_KEYS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic                          eng_busy,
  output logic                          eng_start,
  output logic                          eng_stop,
  output logic [CK_CH_W-1:0]            eng_chan,
  output logic [DATA_W-1:0]             eng_din,
  output logic                          eng_din_vld,
  input  logic [DATA_W-1:0]             eng_dout,
  output logic [KEYS_PER_CH*2*DATA_W-1:0] eng_key
);
  localparam int PAD_W = DATA_W - CK_CTL_FIELD_W;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync[1];

  // address decode
  logic                 hit_ctl;
  logic                 hit_din;
  logic                 hit_dout;
  logic                 hit_key;
  logic [CK_CH_W-1:0]   k_ch;
  logic [CK_KIDX_W-1:0] k_idx;
  logic                 k_lo;

  always_comb begin
    hit_ctl  = (bus_addr == CK_CTL_ADDR);
    hit_din  = (bus_addr == CK_DIN_ADDR);
    hit_dout = (bus_addr == CK_DOUT_ADDR);
    k_ch     = bus_addr[CK_CH_LSB +: CK_CH_W];
    k_idx    = bus_addr[CK_KIDX_LSB +: CK_KIDX_W];
    k_lo     = bus_addr[CK_HL_BIT];
    hit_key  = (bus_addr[ADDR_W-1:CK_KEY_TOP] == CK_KEY_BASE[ADDR_W-1:CK_KEY_TOP])
            && (int'(k_idx) < KEYS_PER_CH)
            && (bus_addr[1:0] == 2'b00);
  end

  // control register
  ctl_t ctl_q;
  ctl_t wr_fields;
  logic wipe;
  logic kprot;
  logic in_swap;
  logic [4:0] unlock_q;

  assign wr_fields = bus_wdata[DATA_W-1 -: CK_CTL_FIELD_W];

  cck_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_ctl    (bus_wr && hit_ctl),
    .wr_fields (wr_fields),
    .wr_start  (bus_wdata[0]),
    .wr_stop   (bus_wdata[1]),
    .busy      (eng_busy),
    .ctl_q     (ctl_q),
    .start_q   (eng_start),
    .stop_q    (eng_stop),
    .wipe      (wipe)
  );

  assign kprot    = ctl_q.kprot;
  assign in_swap  = ctl_q.in_swap;
  assign unlock_q = ctl_q.unlock;
  assign eng_chan = ctl_q.chan;

  // key storage
  logic [DATA_W-1:0] key_word;

  cck_key_bank #(
    .DW    (DATA_W),
    .NCH   (CK_NUM_CH),
    .NKEYS (KEYS_PER_CH),
    .CHW   (CK_CH_W),
    .KIDXW (CK_KIDX_W)
  ) u_keys (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (bus_wr && hit_key),
    .wr_ch    (k_ch),
    .wr_idx   (k_idx),
    .wr_lo    (k_lo),
    .wdata    (bus_wdata),
    .wipe     (wipe),
    .rd_ch    (k_ch),
    .rd_idx   (k_idx),
    .rd_lo    (k_lo),
    .rd_word  (key_word),
    .sel_ch   (ctl_q.chan),
    .sel_keys (eng_key)
  );

  // data paths with byte reversal
  logic [DATA_W-1:0] din_sw;
  logic [DATA_W-1:0] dout_sw;

  cck_byte_swap #(.W(DATA_W)) u_in_swap (
    .en   (ctl_q.in_swap),
    .din  (bus_wdata),
    .dout (din_sw)
  );

  cck_byte_swap #(.W(DATA_W)) u_out_swap (
    .en   (ctl_q.out_swap),
    .din  (eng_dout),
    .dout (dout_sw)
  );

  logic              din_en;
  logic              din_vld_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    din_en    = bus_wr && hit_din;
    din_vld_d = din_en;
    rdata_d   = '0;
    if (hit_ctl) begin
      rdata_d = {ctl_q, PAD_W'(0)};
    end else if (hit_dout) begin
      rdata_d = dout_sw;
    end else if (hit_key) begin
      rdata_d = ctl_q.kprot ? '0 : key_word;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      eng_din <= '0;
    end else if (din_en) begin
      eng_din <= din_sw;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      eng_din_vld <= 1'b0;
    end else begin
      eng_din_vld <= din_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/cck_checker.sv
module cck_checker
  import cck_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [CK_ADDR_W-1:0]   bus_addr,
  input logic [CK_DATA_W-1:0]   bus_wdata,
  input logic [CK_DATA_W-1:0]   bus_rdata,
  input logic                   eng_busy,
  input logic                   eng_start,
  input logic                   eng_din_vld,
  input logic [CK_DATA_W-1:0]   eng_din,
  input logic [CK_KEYS*2*CK_DATA_W-1:0] eng_key,
  input logic                   kprot,
  input logic                   in_swap,
  input logic [4:0]             unlock_q
);
  logic ctl_wr;
  logic key_rd;
  logic code_wr;

  always_comb begin
    ctl_wr  = bus_wr && (bus_addr == CK_CTL_ADDR);
    key_rd  = bus_rd && (bus_addr[CK_ADDR_W-1:CK_KEY_TOP] == CK_KEY_BASE[CK_ADDR_W-1:CK_KEY_TOP]);
    code_wr = ctl_wr && !bus_wdata[31] && (bus_wdata[30:26] == CK_UNLOCK_CODE) && !eng_busy;
  end

  p_start_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> $past(ctl_wr && bus_wdata[0]));

  p_prot_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kprot) |-> $past(code_wr));

  p_key_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_rd && kprot) |=> (bus_rdata == '0));

  p_unlock_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && eng_busy) |=> $stable(unlock_q));

  p_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_wr && kprot) |=> (eng_key == '0));

  p_din_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CK_DIN_ADDR && in_swap) |=>
      (eng_din_vld && eng_din == {$past(bus_wdata[7:0]), $past(bus_wdata[15:8]),
                                  $past(bus_wdata[23:16]), $past(bus_wdata[31:24])}));
endmodule

bind cipher_ctl_regs cck_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .eng_busy    (eng_busy),
  .eng_start   (eng_start),
  .eng_din_vld (eng_din_vld),
  .eng_din     (eng_din),
  .eng_key     (eng_key),
  .kprot       (kprot),
  .in_swap     (in_swap),
  .unlock_q    (unlock_q)
);

// File: tb/cipher_ctl_regs_tb.sv
`timescale 1ns/1ps
module cipher_ctl_regs_tb;
  localparam int KW = 192;

  logic          clk;
  logic          rst_n;
  logic          bus_wr;
  logic          bus_rd;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          eng_busy;
  logic          eng_start;
  logic          eng_stop;
  logic [1:0]    eng_chan;
  logic [31:0]   eng_din;
  logic          eng_din_vld;
  logic [31:0]   eng_dout;
  logic [KW-1:0] eng_key;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] exp_hi [4][3];
  logic [31:0] exp_lo [4][3];

  cipher_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_start(eng_start), .eng_stop(eng_stop),
    .eng_chan(eng_chan), .eng_din(eng_din), .eng_din_vld(eng_din_vld),
    .eng_dout(eng_dout), .eng_key(eng_key)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [11:0] kaddr(input int ch, input int k, input int lo);
    return 12'h300 + 12'(ch * 32) + 12'(k * 8) + 12'(lo * 4);
  endfunction

  function automatic logic [KW-1:0] exp_key(input int ch);
    logic [KW-1:0] v = '0;
    for (int k = 0; k < 3; k++) v[k*64 +: 64] = {exp_hi[ch][k], exp_lo[ch][k]};
    return v;
  endfunction

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic key_write(input int ch, input int k, input int lo, input logic [31:0] d);
    do_write(kaddr(ch, k, lo), d);
    if (lo != 0) exp_lo[ch][k] = d; else exp_hi[ch][k] = d;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    do_read(12'h200, r);
    check("R1 ctl", KW'(r), '0);
    check("R1 pulses", KW'({eng_start, eng_stop, eng_din_vld, eng_chan}), '0);
    check("R1 eng_key", eng_key, '0);
    do_read(kaddr(2, 1, 1), r);
    check("R1 key read", KW'(r), '0);
  endtask

  task automatic t_ctl_fields;
    logic [31:0] r;
    do_write(12'h200, 32'h06C0_FF03);
    check("R3 start pulse", KW'({eng_start, eng_stop}), KW'(2'b11));
    @(negedge clk);
    check("R3 pulse ends", KW'({eng_start, eng_stop}), '0);
    do_read(12'h200, r);
    check("R2 readback", KW'(r), KW'(32'h06C0_0000));
    check("R8 eng_chan", KW'(eng_chan), KW'(2'd2));
    do_write(12'h200, 32'h0000_0000);
  endtask

  task automatic t_keys;
    logic [31:0] r;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 3; k++)
        for (int l = 0; l < 2; l++)
          key_write(c, k, l, 32'hA000_0000 | 32'(c << 8) | 32'(k << 4) | 32'(l));
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 3; k++) begin
        do_read(kaddr(c, k, 0), r);
        check("R11 key hi", KW'(r), KW'(exp_hi[c][k]));
        do_read(kaddr(c, k, 1), r);
        check("R11 key lo", KW'(r), KW'(exp_lo[c][k]));
      end
    do_write(kaddr(1, 3, 0), 32'hDEAD_BEEF);
    do_read(kaddr(1, 3, 0), r);
    check("R11 key3 unmapped", KW'(r), '0);
    for (int c = 0; c < 4; c++) begin
      do_write(12'h200, 32'(c) << 24);
      check("R8 eng_key", eng_key, exp_key(c));
    end
  endtask

  task automatic t_protect;
    logic [31:0] r;
    do_write(12'h200, 32'h8000_0000);
    do_read(12'h200, r);
    check("R4 set", KW'(r), KW'(32'h8000_0000));
    do_read(kaddr(0, 2, 1), r);
    check("R5 masked", KW'(r), '0);
    do_write(12'h200, 32'h4C00_0000);
    do_read(12'h200, r);
    check("R4 wrong code", KW'(r), KW'(32'hCC00_0000));
    eng_busy = 1'b1;
    do_write(12'h200, 32'h5900_0000);
    do_read(12'h200, r);
    check("R7 busy unlock", KW'(r), KW'(32'hCD00_0000));
    do_read(kaddr(3, 0, 0), r);
    check("R7 still masked", KW'(r), '0);
    eng_busy = 1'b0;
    key_write(1, 0, 1, 32'h1234_5678);
    check("R5 write while protected", eng_key, exp_key(1));
    do_write(12'h200, 32'h5800_0000);
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 3; k++) begin
        exp_hi[c][k] = '0;
        exp_lo[c][k] = '0;
      end
    do_read(12'h200, r);
    check("R6 released", KW'(r), KW'(32'h5800_0000));
    check("R6 wiped eng_key", eng_key, '0);
    do_read(kaddr(2, 2, 0), r);
    check("R6 wiped read", KW'(r), '0);
    key_write(0, 1, 0, 32'h0BAD_F00D);
    do_write(12'h200, 32'h5800_0000);
    do_read(kaddr(0, 1, 0), r);
    check("R6 unprotected keep", KW'(r), KW'(32'h0BAD_F00D));
  endtask

  task automatic t_swap;
    logic [31:0] r;
    do_write(12'h200, 32'h0080_0000);
    do_write(12'h208, 32'h1122_3344);
    check("R9 din swapped", KW'({eng_din_vld, eng_din}), KW'({1'b1, 32'h4433_2211}));
    @(negedge clk);
    check("R9 vld pulse", KW'(eng_din_vld), '0);
    do_write(12'h200, 32'h0000_0000);
    do_write(12'h208, 32'h1122_3344);
    check("R9 din straight", KW'(eng_din), KW'(32'h1122_3344));
    eng_dout = 32'hAABB_CCDD;
    do_read(12'h20C, r);
    check("R10 dout straight", KW'(r), KW'(32'hAABB_CCDD));
    do_write(12'h200, 32'h0040_0000);
    do_read(12'h20C, r);
    check("R10 dout swapped", KW'(r), KW'(rev(32'hAABB_CCDD)));
  endtask

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_wdata = '0; eng_busy = 1'b0; eng_dout = '0;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 3; k++) begin
        exp_hi[c][k] = '0;
        exp_lo[c][k] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctl_fields();
    t_keys();
    t_protect();
    t_swap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule